// File: doc/BRIEF.md
# Wait-State Memory Cycle Sequencer

This block turns single-byte memory requests into timed bus cycles for a data-mover engine. A request carries a direction flag, a 22-bit byte address and, for writes, one data byte. Once accepted, the block drives the address, the write data and exactly one strobe (read or write). It holds them for one base cycle plus a programmed number of wait cycles, so that slow memories and peripherals have time to respond. When the access ends, it returns a one-cycle completion pulse together with the byte read from the bus.

The wait counts live in a byte-wide configuration register that software can both write and read. The low nibble is the read wait count and the high nibble is the write wait count. Every read uses the read count, whether it fetches a transfer descriptor or moves payload data. The engine above this block owns arbitration and descriptor sequencing.

The request side is a valid/ready stream. The requester holds its fields while `req_valid` is high and `req_ready` is low, and a transfer happens on the clock edge where both are high. `req_ready` is high only while no access is in flight. The completion side has no back-pressure: `rsp_valid` is a single-cycle pulse that the requester must take in that cycle.

Top module: `wsb_sequencer`

## Requirements
- R1: After reset the configuration register reads 0x56 on `cfg_rdata` when `cfg_addr` is 0x9, which is 6 read waits (bits 3:0) and 5 write waits (bits 7:4). Any other `cfg_addr` reads 0x00.
- R2: A write with `cfg_we` high at `cfg_addr` 0x9 replaces all 8 bits of the register. A write at any other offset leaves the value read back at 0x9 unchanged.
- R3: An accepted read raises `mem_rd` for exactly 1 + bits 3:0 consecutive cycles. A count of zero gives a single cycle.
- R4: An accepted write raises `mem_wr` for exactly 1 + bits 7:4 consecutive cycles. A count of zero gives a single cycle.
- R5: While a strobe is high, `mem_addr` holds the request address and, for writes, `mem_wdata` holds the request byte. `mem_rd` and `mem_wr` are never high together.
- R6: For a read, `rsp_rdata` equals the value that `mem_rdata` had in the last cycle in which `mem_rd` was high.
- R7: `rsp_valid` is high for exactly one cycle, in the cycle right after the last strobe cycle. Both strobes are low in that cycle.
- R8: `req_ready` is high only when idle. The strobe rises in the cycle after acceptance. `req_ready` stays low from acceptance through the `rsp_valid` cycle and returns high in the cycle after it, so strobes are low for at least one cycle between accesses.
- R9: The wait count is taken from the register at acceptance. A register write during an access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 22 | Byte address of the access |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| mem_addr | output | 22 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Bus read data |

## Verification
The assertions assume that reset is held low for at least one clock and that `req_write` is a known value whenever `req_valid` is high. They make no assumption about the memory's read data or about when the configuration register is written. The bench drives every input half a cycle away from the active edge. It offers a request only when it expects the block to be idle, and it drops `req_valid` right after acceptance. Configuration writes are issued both between accesses and in the middle of an access, so that the latch-at-acceptance rule is exercised.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE   = 2'd2
  } wsb_state_e;
endpackage

// File: rtl/wsb_cfg_reg.sv
module wsb_cfg_reg #(
  parameter int CFG_AW    = 4,
  parameter int OFFSET    = 9,
  parameter int WAIT_W    = 4,
  parameter int RESET_VAL = 'h56
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [CFG_AW-1:0]     addr,
  input  logic [2*WAIT_W-1:0]   wdata,
  output logic [2*WAIT_W-1:0]   rdata,
  output logic [WAIT_W-1:0]     rd_wait,
  output logic [WAIT_W-1:0]     wr_wait
);
  localparam int REG_W = 2 * WAIT_W;
  localparam logic [REG_W-1:0]  RST_V = REG_W'(RESET_VAL);
  localparam logic [CFG_AW-1:0] HIT_A = CFG_AW'(OFFSET);

  logic [REG_W-1:0] cfg_q;
  logic             hit;

  assign hit = (addr == HIT_A);

  always_ff @(posedge clk) begin
    if (!rst_n)          cfg_q <= RST_V;
    else if (we && hit)  cfg_q <= wdata;
  end

  assign rdata   = hit ? cfg_q : '0;
  assign rd_wait = cfg_q[WAIT_W-1:0];
  assign wr_wait = cfg_q[REG_W-1:WAIT_W];

  // R2: a write at another offset does not disturb the stored value
  p_foreign_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit) |=> (rd_wait == $past(rd_wait) && wr_wait == $past(wr_wait)));
endmodule

// File: rtl/wsb_stretch_ctr.sv
module wsb_stretch_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R3/R4: the controller never asks for a decrement past zero
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero);
  // R9: load and decrement never requested together
  p_load_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && dec));
endmodule

// File: rtl/wsb_cycle_ctrl.sv
module wsb_cycle_ctrl
  import wsb_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [WAIT_W-1:0] rd_wait,
  input  logic [WAIT_W-1:0] wr_wait,
  output logic              ctr_load,
  output logic [WAIT_W-1:0] ctr_load_val,
  output logic              ctr_dec,
  input  logic              ctr_zero,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata
);
  wsb_state_e        state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              take;

  assign req_ready    = (state_q == ST_IDLE);
  assign take         = req_ready && req_valid;
  assign ctr_load     = take;
  assign ctr_load_val = req_write ? wr_wait : rd_wait;
  assign ctr_dec      = (state_q == ST_ACCESS) && !ctr_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ST_ACCESS;
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        ST_ACCESS: if (ctr_zero) begin
          state_q <= ST_DONE;
          if (!wr_q) rdata_q <= mem_rdata;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_rd    = (state_q == ST_ACCESS) && !wr_q;
  assign mem_wr    = (state_q == ST_ACCESS) && wr_q;
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_rdata = rdata_q;

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> (!(mem_rd || mem_wr) || ($stable(mem_addr) && $stable(mem_wdata))));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(mem_rd || mem_wr));
  p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rd || mem_wr));
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(mem_rd || mem_wr || rsp_valid));
  p_strobe_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_wr == $past(req_write)) && (mem_rd == !$past(req_write)));
endmodule

// File: rtl/wsb_sequencer.sv
module wsb_sequencer #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 8,
  parameter int WAIT_W    = 4,
  parameter int CFG_AW    = 4,
  parameter int CFG_OFFS  = 9,
  parameter int CFG_RESET = 'h56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [2*WAIT_W-1:0] cfg_wdata,
  output logic [2*WAIT_W-1:0] cfg_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [WAIT_W-1:0] rd_wait, wr_wait, ld_val;
  logic              ld, dec, zero;

  wsb_cfg_reg #(.CFG_AW(CFG_AW), .OFFSET(CFG_OFFS), .WAIT_W(WAIT_W),
                .RESET_VAL(CFG_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .rd_wait(rd_wait), .wr_wait(wr_wait));

  wsb_stretch_ctr #(.W(WAIT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .dec(dec), .zero(zero));

  wsb_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rd_wait(rd_wait), .wr_wait(wr_wait),
    .ctr_load(ld), .ctr_load_val(ld_val), .ctr_dec(dec), .ctr_zero(zero),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata));
endmodule

// File: tb/sim_wsb_sequencer.sv
module sim_wsb_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, mem_rd, mem_wr;
  logic [7:0]  rsp_rdata, cfg_rdata, mem_wdata, mem_rdata;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = 4'h9;
  logic [7:0]  cfg_wdata = '0;
  logic [21:0] mem_addr;
  logic [7:0]  ph;
  logic [7:0]  cfg_model;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  wsb_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata));

  // memory model: data depends on address and on how long the read strobe has been high
  always_ff @(posedge clk) ph <= mem_rd ? ph + 8'd1 : 8'd0;
  assign mem_rdata = mem_addr[7:0] ^ ph;

  function automatic logic [7:0] exp_rd(input logic [21:0] a, input logic [3:0] n);
    return a[7:0] ^ {4'h0, n};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 4'h9;
    if (a == 4'h9) cfg_model = d;
  endtask

  task automatic run(input bit wr, input logic [21:0] a, input logic [7:0] d,
                     input bit mid, input logic [7:0] mid_val);
    logic [3:0] n;
    int cnt;
    n = wr ? cfg_model[7:4] : cfg_model[3:0];
    @(negedge clk);
    chk(req_ready, "R8 ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (rsp_valid) break;
      if (mid && i == 0) begin cfg_we = 1'b1; cfg_addr = 4'h9; cfg_wdata = mid_val; end
      else cfg_we = 1'b0;
      if (wr) chk(mem_wr && !mem_rd, "R4 write strobe", 32'({mem_rd, mem_wr}), 1);
      else    chk(mem_rd && !mem_wr, "R3 read strobe", 32'({mem_rd, mem_wr}), 2);
      chk(mem_addr == a, "R5 address hold", 32'(mem_addr), 32'(a));
      if (wr) chk(mem_wdata == d, "R5 wdata hold", 32'(mem_wdata), 32'(d));
      chk(!req_ready, "R8 busy", 32'(req_ready), 0);
      cnt++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    if (mid) cfg_model = mid_val;
    if (wr) chk(cnt == n + 1, "R4 write length (R9 latch)", 32'(cnt), 32'(n) + 1);
    else    chk(cnt == n + 1, "R3 read length (R9 latch)", 32'(cnt), 32'(n) + 1);
    chk(rsp_valid && !mem_rd && !mem_wr, "R7 done with strobes low",
        32'({rsp_valid, mem_rd, mem_wr}), 4);
    chk(!req_ready, "R8 busy in done cycle", 32'(req_ready), 0);
    if (!wr) chk(rsp_rdata == exp_rd(a, n), "R6 read data", 32'(rsp_rdata), 32'(exp_rd(a, n)));
    @(negedge clk);
    chk(!rsp_valid, "R7 single pulse", 32'(rsp_valid), 0);
    chk(req_ready && !mem_rd && !mem_wr, "R8 idle gap", 32'({req_ready, mem_rd, mem_wr}), 4);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cfg_model = 8'h56;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 8'h56, "R1 reset value", 32'(cfg_rdata), 32'h56);
    chk(req_ready && !mem_rd && !mem_wr && !rsp_valid, "R8 reset idle",
        32'({req_ready, mem_rd, mem_wr, rsp_valid}), 8);
    cfg_addr = 4'h3; #1;
    chk(cfg_rdata == 8'h00, "R1 other offset reads zero", 32'(cfg_rdata), 0);
    cfg_addr = 4'h9;
    // reset timing: 6 read waits, 5 write waits
    run(1'b0, 22'h12345, 8'h00, 1'b0, 8'h00);
    run(1'b1, 22'h3FFFFF, 8'hA5, 1'b0, 8'h00);
    // R2: foreign offset ignored
    cfg_write(4'h8, 8'hFF);
    cfg_write(4'hA, 8'h11);
    #1;
    chk(cfg_rdata == 8'h56, "R2 foreign write ignored", 32'(cfg_rdata), 32'h56);
    // zero waits
    cfg_write(4'h9, 8'h00);
    #1;
    chk(cfg_rdata == 8'h00, "R2 write at 0x9", 32'(cfg_rdata), 0);
    run(1'b0, 22'h000001, 8'h00, 1'b0, 8'h00);
    run(1'b1, 22'h000002, 8'h3C, 1'b0, 8'h00);
    // max waits
    cfg_write(4'h9, 8'hFF);
    run(1'b0, 22'h2AAAAA, 8'h00, 1'b0, 8'h00);
    run(1'b1, 22'h155555, 8'h5A, 1'b0, 8'h00);
    // R9: change during an access
    cfg_write(4'h9, 8'h73);
    run(1'b0, 22'h0ABCDE, 8'h00, 1'b1, 8'h1E);
    run(1'b0, 22'h0ABCDF, 8'h00, 1'b0, 8'h00);
    run(1'b1, 22'h0ABCE0, 8'h99, 1'b1, 8'h42);
    run(1'b1, 22'h0ABCE1, 8'h98, 1'b0, 8'h00);
    // random mix
    for (int k = 0; k < 60; k++) begin
      if ($urandom % 3 == 0) cfg_write(4'h9, 8'($urandom));
      run(1'($urandom), 22'($urandom), 8'($urandom), ($urandom % 5 == 0), 8'($urandom));
    end
    #1;
    chk(cfg_rdata == cfg_model, "R2 final readback", 32'(cfg_rdata), 32'(cfg_model));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule